// File: doc/BRIEF.md
# Windowed Tri-State Phase-Frequency Detector with Lock Qualifier

This block compares two pulse trains that are synchronous to a master clock: a divided reference (`fr`) and a divided oscillator feedback (`fv`). On each rising edge it runs an edge-triggered up/down machine. It issues an up pulse when the feedback leads or runs fast. It issues a down pulse when the reference leads or the feedback runs slow. While neither pulse is open it drives a neutral level.

Each comparison measures the phase error as the number of master-clock cycles between the two edges. If the last comparison fell inside a programmable window, the coarse output is released to high impedance (`pdb_oe` low). The output stays released until a new pulse grows past the window. An active-low lock flag asserts after a run of in-window comparisons. A synchronous `sync` strobe, issued after new divider data is loaded, returns everything to a neutral, unlocked state.

The machine has three states. PH_IDLE means no pulse is open. PH_UP means the feedback edge came first. PH_DN means the reference edge came first. The transitions are as follows:
- IDLE to UP on a feedback edge alone.
- IDLE to DN on a reference edge alone.
- IDLE stays in IDLE on coincident edges, which counts as a comparison with error 0.
- UP returns to IDLE on a reference edge.
- DN returns to IDLE on a feedback edge.
- Any state goes to IDLE on `sync`.

Top module: `pfd_window_lock`

## Requirements
- R1: During and after reset, with no edges applied, pdb_up=0, pdb_dn=0, pdb_oe=1 and ld_n=1.
- R2: An `fv` rising edge, with no pulse open and no coincident `fr` edge, raises pdb_up from the same clock edge that detects it. The pulse lasts until the clock edge that detects the next `fr` rising edge, when pdb_up returns to 0.
- R3: An `fr` rising edge, with no pulse open and no coincident `fv` edge, raises pdb_dn in the same way as R2. The pulse ends at the clock edge that detects the next `fv` rising edge.
- R4: Rising edges of `fr` and `fv` detected at the same clock edge produce no pulse and count as a comparison with error 0.
- R5: pdb_up and pdb_dn are never 1 together.
- R6: The error of a comparison equals the number of master-clock cycles between the two detected edges. When it is at most `window`, the comparison is in-window and the output is released: pdb_oe=0, pdb_up=0 and pdb_dn=0.
- R7: After an out-of-window comparison, pdb_oe is 1.
- R8: ld_n goes to 0 at the clock edge that completes the 4th consecutive in-window comparison. It returns to 1 at the edge that completes the first out-of-window comparison.
- R9: While `sync` is 1 at a clock edge, edges on `fr`/`fv` are ignored. After that edge: no pulse is open, pdb_oe=1, ld_n=1, and the lock run and the window history are cleared.
- R10: Further edges of the leading input while a pulse is open do not restart it. The running error count saturates at 2^PH_W-1.
- R11: While released, an open pulse whose running count exceeds `window` sets pdb_oe=1 and drives pdb_up or pdb_dn according to its direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fr | input | 1 | Divided reference pulse train |
| fv | input | 1 | Divided feedback pulse train |
| sync | input | 1 | Resynchronise strobe, active high |
| window | input | PH_W | Lock window in master-clock cycles |
| pdb_up | output | 1 | Up drive (feedback leads) |
| pdb_dn | output | 1 | Down drive (reference leads) |
| pdb_oe | output | 1 | Coarse output drive enable; 0 = high impedance |
| ld_n | output | 1 | Lock detect, active low |

## Verification
Each input edge is detected at the first clock edge that sees the input high. Every output is registered and changes at that same edge. The bench therefore changes `fr`, `fv` and `sync` at falling edges and reads the outputs at the next falling edge, half a period after the update.

A pulse opened at clock edge t carries a running count of k at edge t+k−1. A comparison closed at edge t+d has error d. Its effect on pdb_oe and ld_n is checked at the falling edge right after that closing edge. A `sync` result is due one clock edge after the strobe. Expected levels come from a small arithmetic model of the window and lock run. The sweep covers every window value from 0 to 3, both directions, and errors from 0 to 5. It also covers a run of several hundred cycles that reaches the counter's saturation limit.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_UP   = 2'd1,
        PH_DN   = 2'd2
    } ph_state_t;
endpackage

// File: rtl/pfd_edge_det.sv
module pfd_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise
);
    logic sig_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig;
    end

    assign rise = sig & ~sig_q;
endmodule

// File: rtl/pfd_phase_fsm.sv
module pfd_phase_fsm
    import pfd_pkg::*;
#(
    parameter int PH_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sync,
    input  logic            fr_rise,
    input  logic            fv_rise,
    output ph_state_t       nxt_state,
    output logic [PH_W-1:0] nxt_cnt,
    output logic            done,
    output logic [PH_W-1:0] err
);
    localparam logic [PH_W-1:0] CNT_MAX = {PH_W{1'b1}};
    localparam logic [PH_W-1:0] CNT_ONE = {{(PH_W-1){1'b0}}, 1'b1};

    ph_state_t       state_q;
    logic [PH_W-1:0] cnt_q;
    logic [PH_W-1:0] cnt_inc;

    assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_ONE;

    // next-state and comparison result
    always_comb begin
        nxt_state = state_q;
        nxt_cnt   = cnt_q;
        done      = 1'b0;
        err       = cnt_q;
        if (sync) begin
            nxt_state = PH_IDLE;
            nxt_cnt   = '0;
        end else begin
            unique case (state_q)
                PH_IDLE: begin
                    if (fr_rise && fv_rise) begin
                        done = 1'b1;
                        err  = '0;
                    end else if (fv_rise) begin
                        nxt_state = PH_UP;
                        nxt_cnt   = CNT_ONE;
                    end else if (fr_rise) begin
                        nxt_state = PH_DN;
                        nxt_cnt   = CNT_ONE;
                    end
                end
                PH_UP: begin
                    if (fr_rise) begin
                        done      = 1'b1;
                        nxt_state = PH_IDLE;
                        nxt_cnt   = '0;
                    end else begin
                        nxt_cnt = cnt_inc;
                    end
                end
                PH_DN: begin
                    if (fv_rise) begin
                        done      = 1'b1;
                        nxt_state = PH_IDLE;
                        nxt_cnt   = '0;
                    end else begin
                        nxt_cnt = cnt_inc;
                    end
                end
                default: begin
                    nxt_state = PH_IDLE;
                    nxt_cnt   = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= nxt_state;
            cnt_q   <= nxt_cnt;
        end
    end
endmodule

// File: rtl/pfd_lock_qual.sv
module pfd_lock_qual #(
    parameter int PH_W   = 8,
    parameter int LOCK_N = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sync,
    input  logic            done,
    input  logic [PH_W-1:0] err,
    input  logic [PH_W-1:0] window,
    output logic            nxt_inwin,
    output logic            nxt_locked
);
    localparam int LK_W = $clog2(LOCK_N + 1);
    localparam logic [LK_W-1:0] LK_TOP = LK_W'(LOCK_N);
    localparam logic [LK_W-1:0] LK_ONE = LK_W'(1);

    logic            inwin_q;
    logic [LK_W-1:0] run_q;
    logic [LK_W-1:0] run_d;
    logic            fits;

    assign fits = (err <= window);

    always_comb begin
        nxt_inwin = inwin_q;
        run_d     = run_q;
        if (sync) begin
            nxt_inwin = 1'b0;
            run_d     = '0;
        end else if (done) begin
            nxt_inwin = fits;
            if (!fits)               run_d = '0;
            else if (run_q < LK_TOP) run_d = run_q + LK_ONE;
        end
    end

    assign nxt_locked = (run_d >= LK_TOP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inwin_q <= 1'b0;
            run_q   <= '0;
        end else begin
            inwin_q <= nxt_inwin;
            run_q   <= run_d;
        end
    end
endmodule

// File: rtl/pfd_window_lock.sv
module pfd_window_lock
    import pfd_pkg::*;
#(
    parameter int PH_W   = 8,
    parameter int LOCK_N = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fr,
    input  logic            fv,
    input  logic            sync,
    input  logic [PH_W-1:0] window,
    output logic            pdb_up,
    output logic            pdb_dn,
    output logic            pdb_oe,
    output logic            ld_n
);
    localparam int N_CH = 2;

    logic [N_CH-1:0] raw_in;
    logic [N_CH-1:0] rise;
    ph_state_t       nxt_state;
    logic [PH_W-1:0] nxt_cnt;
    logic            done;
    logic [PH_W-1:0] err;
    logic            nxt_inwin;
    logic            nxt_locked;
    logic            over_win;
    logic            hold;

    assign raw_in = {fv, fr};

    for (genvar gi = 0; gi < N_CH; gi++) begin : g_edge
        pfd_edge_det i_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .sig  (raw_in[gi]),
            .rise (rise[gi])
        );
    end

    pfd_phase_fsm #(.PH_W(PH_W)) i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync     (sync),
        .fr_rise  (rise[0]),
        .fv_rise  (rise[1]),
        .nxt_state(nxt_state),
        .nxt_cnt  (nxt_cnt),
        .done     (done),
        .err      (err)
    );

    pfd_lock_qual #(.PH_W(PH_W), .LOCK_N(LOCK_N)) i_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync      (sync),
        .done      (done),
        .err       (err),
        .window    (window),
        .nxt_inwin (nxt_inwin),
        .nxt_locked(nxt_locked)
    );

    // release while the history is in-window and no open pulse has outgrown it
    assign over_win = (nxt_state != PH_IDLE) && (nxt_cnt > window);
    assign hold     = nxt_inwin && !over_win;

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pdb_up <= 1'b0;
            pdb_dn <= 1'b0;
            pdb_oe <= 1'b1;
            ld_n   <= 1'b1;
        end else begin
            pdb_up <= !hold && (nxt_state == PH_UP);
            pdb_dn <= !hold && (nxt_state == PH_DN);
            pdb_oe <= !hold;
            ld_n   <= !nxt_locked;
        end
    end
endmodule

// File: rtl/pfd_window_lock_chk.sv
module pfd_window_lock_chk (
    input logic clk,
    input logic rst_n,
    input logic fr,
    input logic fv,
    input logic sync,
    input logic pdb_up,
    input logic pdb_dn,
    input logic pdb_oe,
    input logic ld_n
);
    a_r5_up_dn_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(pdb_up && pdb_dn));

    a_r6_released_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !pdb_oe |-> (!pdb_up && !pdb_dn));

    a_r9_sync_clears: assert property (@(posedge clk) disable iff (!rst_n)
        sync |=> (!pdb_up && !pdb_dn && pdb_oe && ld_n));

    a_r4_coincident_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fr) && $rose(fv) && !sync) |=> (!pdb_up && !pdb_dn));

    a_r8_locked_drive_needs_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_n && pdb_oe) |-> (pdb_up || pdb_dn));
endmodule

bind pfd_window_lock pfd_window_lock_chk i_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .fr    (fr),
    .fv    (fv),
    .sync  (sync),
    .pdb_up(pdb_up),
    .pdb_dn(pdb_dn),
    .pdb_oe(pdb_oe),
    .ld_n  (ld_n)
);

// File: tb/test_pfd_window_lock.sv
module test_pfd_window_lock;
    localparam int PH_W = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            fr = 1'b0;
    logic            fv = 1'b0;
    logic            sync = 1'b0;
    logic [PH_W-1:0] window = '0;
    logic            pdb_up, pdb_dn, pdb_oe, ld_n;

    int vectors = 0;
    int fails   = 0;
    int win     = 0;
    bit m_inwin = 1'b0;
    int m_lock  = 0;

    always #2 clk = ~clk;

    pfd_window_lock #(.PH_W(PH_W), .LOCK_N(4)) i_pfd_window_lock (
        .clk(clk), .rst_n(rst_n), .fr(fr), .fv(fv), .sync(sync),
        .window(window), .pdb_up(pdb_up), .pdb_dn(pdb_dn),
        .pdb_oe(pdb_oe), .ld_n(ld_n)
    );

    task automatic chk(input string req, input bit up, input bit dn, input bit oe, input bit ldn);
        logic [3:0] act, exp;
        act = {pdb_up, pdb_dn, pdb_oe, ld_n};
        exp = {up, dn, oe, ldn};
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s win=%0d: up/dn/oe/ld_n actual %b expected %b", req, win, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_idle(input string req);
        chk(req, 1'b0, 1'b0, !m_inwin, !(m_lock >= 4));
    endtask

    task automatic model_done(input int d);
        bit in_w;
        in_w = (d <= win);
        m_inwin = in_w;
        m_lock  = in_w ? ((m_lock < 4) ? m_lock + 1 : 4) : 0;
    endtask

    task automatic do_sync();
        sync = 1'b1;
        tick();
        sync = 1'b0;
        m_inwin = 1'b0;
        m_lock  = 0;
        chk("R9", 1'b0, 1'b0, 1'b1, 1'b1);
    endtask

    // one comparison: leading input first, lagging input d cycles later
    task automatic compare(input bit fv_first, input int d);
        bit hold;
        if (d == 0) begin
            fr = 1'b1; fv = 1'b1;
            tick();
            fr = 1'b0; fv = 1'b0;
            model_done(0);
            chk_idle("R4 R6 R8");
        end else begin
            if (fv_first) fv = 1'b1; else fr = 1'b1;
            for (int k = 1; k <= d; k++) begin
                tick();
                hold = m_inwin && (k <= win);
                chk(fv_first ? "R2 R5 R11" : "R3 R5 R11",
                    !hold && fv_first, !hold && !fv_first, !hold, !(m_lock >= 4));
                if (k == 1) begin
                    if (fv_first) fv = 1'b0; else fr = 1'b0;
                end
                if (k == d) begin
                    if (fv_first) fr = 1'b1; else fv = 1'b1;
                end
            end
            tick();
            fr = 1'b0; fv = 1'b0;
            model_done(d);
            chk_idle((d <= win) ? "R6 R8" : "R7 R8");
        end
        tick();
        chk_idle("R6 R7");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", 1'b0, 1'b0, 1'b1, 1'b1);
        rst_n = 1'b1;
        tick();
        tick();
        chk("R1", 1'b0, 1'b0, 1'b1, 1'b1);

        // sweep window, direction and error
        for (int w = 0; w <= 3; w++) begin
            win = w;
            window = PH_W'(w);
            for (int f = 0; f <= 1; f++) begin
                for (int d = 0; d <= 5; d++) begin
                    do_sync();
                    for (int n = 0; n < 5; n++) compare(f[0], d);
                    compare(f[0], w + 1);
                end
            end
        end

        // R9: sync in the middle of a released pulse, after lock
        win = 3;
        window = PH_W'(3);
        do_sync();
        for (int n = 0; n < 4; n++) compare(1'b0, 1);
        chk("R8", 1'b0, 1'b0, 1'b0, 1'b0);
        fr = 1'b1;
        tick();
        fr = 1'b0;
        chk("R6 R3", 1'b0, 1'b0, 1'b0, 1'b0);
        sync = 1'b1;
        fv = 1'b1;
        tick();
        sync = 1'b0;
        m_inwin = 1'b0;
        m_lock = 0;
        chk("R9", 1'b0, 1'b0, 1'b1, 1'b1);
        fv = 1'b0;
        tick();
        chk("R9", 1'b0, 1'b0, 1'b1, 1'b1);
        tick();
        chk("R9", 1'b0, 1'b0, 1'b1, 1'b1);

        // R10: long pulse with an extra leading edge; count saturates at 255
        win = 254;
        window = PH_W'(254);
        do_sync();
        compare(1'b1, 2);
        fv = 1'b1;
        for (int k = 1; k <= 300; k++) begin
            tick();
            if (k <= 254) chk("R10", 1'b0, 1'b0, 1'b0, 1'b1);
            else          chk("R10 R11", 1'b1, 1'b0, 1'b1, 1'b1);
            if (k == 1)  fv = 1'b0;
            if (k == 10) fv = 1'b1;
            if (k == 11) fv = 1'b0;
            if (k == 300) fr = 1'b1;
        end
        tick();
        fr = 1'b0;
        model_done(255);
        chk_idle("R7 R10");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule